// File: doc/BRIEF.md
# PCM Time-Slot Channel with Sample Queues and DMA Request Handshake

This block serves one channel of a time-division PCM serial link. It counts bit periods to build a frame, drives the frame sync strobe, and places the channel's sample in a window of the frame set by a 10-bit start position. During that window it shifts one sample out of a transmit queue onto the data line and captures one sample from the receive line into a receive queue. The frame advances one bit per clock cycle. The bit-clock divider and companding conversion sit outside the block.

Each queue has its own threshold. When a queue crosses its threshold, the block can raise a DMA request. The request stays raised until the DMA engine reports the end of a burst, and only then is the threshold checked again. The same conditions appear as interrupt causes, so software can move the data when DMA is off. Queue overrun, queue underrun and a burst-end report with no request outstanding are recorded as sticky causes.

Top module: `pcm_chan`

## Requirements
- R1: Each queue holds 32 samples and reports its occupancy on its level output. A push into a full transmit queue is ignored, and the level stays at 32.
- R2: A frame lasts `cfg_slots`×8 bit cycles, with `cfg_slots` clamped to 4..128. `pcm_fs` is high in bit 0 of each frame when `cfg_fs_long`=0, and in bits 0..7 when it is 1. While `cfg_en`=0 the frame is held at bit 0 and `pcm_fs` stays low.
- R3: The 8-bit sample occupies bits `cfg_start` .. `cfg_start`+7 of the frame. `pcm_dtx_oe` is high only in those bits.
- R4: With `cfg_lsb_first`=0 the sample's bit 7 is sent first. With `cfg_lsb_first`=1 its bit 0 is sent first. Receive assembly uses the same order.
- R5: The received sample is pushed into the receive queue at the last bit of the window. If the queue is full at that cycle, even when it is popped in the same cycle, the sample is dropped and cause bit 2 (receive overrun) is set.
- R6: If the transmit queue is empty when the window starts, the window sends zeros and cause bit 3 (transmit underrun) is set.
- R7: With `cfg_tri_last`=1, `pcm_dtx_oe` is low during the last bit of the window.
- R8: Cause bit 0 is high while the receive level is at least `cfg_rx_thr`. Cause bit 1 is high while the transmit level is below `cfg_tx_thr`.
- R9: With `cfg_dma_en`=1, a direction's request rises one cycle after its threshold cause holds. The request then stays high until that direction's burst-end input is pulsed, and is low in the cycle after the pulse. The threshold is re-evaluated from the following cycle onward.
- R10: A burst-end pulse on either direction while that direction's request is low sets cause bit 4 (DMA fault).
- R11: Cause bits 2..4 are sticky and are cleared by a one-cycle pulse on the matching `irq_clr` bit. A new event in the same cycle wins over the clear. `irq` is the OR of all five cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit period per cycle |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_slots | input | 8 | Slots per frame (clamped 4..128) |
| cfg_start | input | 10 | First bit of the channel's window |
| cfg_fs_long | input | 1 | 1: 8-cycle sync, 0: 1-cycle sync |
| cfg_lsb_first | input | 1 | Bit order of the sample |
| cfg_tri_last | input | 1 | Release the line in the last bit |
| cfg_dma_en | input | 1 | Allow DMA requests |
| cfg_rx_thr | input | 6 | Receive threshold |
| cfg_tx_thr | input | 6 | Transmit threshold |
| pcm_fs | output | 1 | Frame sync |
| pcm_dtx | output | 1 | Serial transmit data |
| pcm_dtx_oe | output | 1 | Transmit drive enable |
| pcm_drx | input | 1 | Serial receive data |
| rx_pop | input | 1 | Pop the receive queue |
| rx_data | output | 8 | Oldest received sample |
| rx_level | output | 6 | Receive occupancy |
| tx_push | input | 1 | Push into the transmit queue |
| tx_data | input | 8 | Sample to push |
| tx_level | output | 6 | Transmit occupancy |
| rx_dreq | output | 1 | Receive DMA request |
| rx_dend | input | 1 | Receive burst end |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_dend | input | 1 | Transmit burst end |
| irq_clr | input | 5 | Clear sticky causes |
| irq_cause | output | 5 | Cause vector |
| irq | output | 1 | Interrupt |

## Verification
The case that matters is a burst-end pulse arriving in the same cycle as a threshold condition that is still true. The bench leaves the transmit queue empty with its threshold above zero, pulses the burst-end input, and expects the request to be low in the next cycle and high again in the cycle after. A second coincidence is a window end meeting a full receive queue. The bench stops draining, lets a further window complete, and expects the level to stay at 32, the sample to be absent from the scoreboard, and the overrun cause to be set.

// File: rtl/pcm_chan_pkg.sv
package pcm_chan_pkg;
   localparam int CAUSE_N   = 5;
   localparam int C_RX_THR  = 0;
   localparam int C_TX_THR  = 1;
   localparam int C_RX_OVR  = 2;
   localparam int C_TX_UDR  = 3;
   localparam int C_DMA_FLT = 4;
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          rd,
   output logic [W-1:0]  rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("pcm_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_wr, do_rd;

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + AW'(1);
         if (do_rd) rp <= rp + AW'(1);
         level <= level + LW'(do_wr) - LW'(do_rd);
      end
   end

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd) |=> (level == LW'(DEPTH)));
   // R1
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd && !wr) |=> (level == '0));
endmodule

// File: rtl/pcm_dma_hs.sv
module pcm_dma_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_en,
   input  logic cond,
   input  logic dend,
   output logic dreq,
   output logic fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        dreq <= 1'b0;
      else if (dend)                     dreq <= 1'b0;
      else if (!dreq && dma_en && cond)  dreq <= 1'b1;
   end

   assign fault = dend && !dreq;

   // R9
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dend |=> !dreq);
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dend) |=> dreq);
endmodule

// File: rtl/pcm_chan.sv
module pcm_chan import pcm_chan_pkg::*; #(
   parameter int SAMPLE_W   = 8,
   parameter int FIFO_DEPTH = 32,
   parameter int START_W    = 10,
   parameter int SLOT_BITS  = 8,
   parameter int MIN_SLOTS  = 4,
   parameter int MAX_SLOTS  = 128,
   parameter int FS_LONG    = 8,
   localparam int LW        = $clog2(FIFO_DEPTH + 1),
   localparam int SLW       = $clog2(MAX_SLOTS + 1),
   localparam int IW        = $clog2(SAMPLE_W),
   localparam int CW        = START_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_en,
   input  logic [SLW-1:0]      cfg_slots,
   input  logic [START_W-1:0]  cfg_start,
   input  logic                cfg_fs_long,
   input  logic                cfg_lsb_first,
   input  logic                cfg_tri_last,
   input  logic                cfg_dma_en,
   input  logic [LW-1:0]       cfg_rx_thr,
   input  logic [LW-1:0]       cfg_tx_thr,
   output logic                pcm_fs,
   output logic                pcm_dtx,
   output logic                pcm_dtx_oe,
   input  logic                pcm_drx,
   input  logic                rx_pop,
   output logic [SAMPLE_W-1:0] rx_data,
   output logic [LW-1:0]       rx_level,
   input  logic                tx_push,
   input  logic [SAMPLE_W-1:0] tx_data,
   output logic [LW-1:0]       tx_level,
   output logic                rx_dreq,
   input  logic                rx_dend,
   output logic                tx_dreq,
   input  logic                tx_dend,
   input  logic [CAUSE_N-1:0]  irq_clr,
   output logic [CAUSE_N-1:0]  irq_cause,
   output logic                irq
);
   if (MAX_SLOTS * SLOT_BITS > (1 << START_W)) begin : g_bad_frame
      $error("pcm_chan: frame longer than the start field can address");
   end
   if ((1 << IW) != SAMPLE_W) begin : g_bad_sample
      $error("pcm_chan: SAMPLE_W must be a power of two");
   end

   // frame timing
   logic [SLW-1:0] eff_slots;
   logic [CW-1:0]  bcnt, frame_last, off;
   logic           in_slot, slot_first, slot_last;
   logic [IW-1:0]  idx, pos;

   always_comb begin
      if (cfg_slots < SLW'(MIN_SLOTS))      eff_slots = SLW'(MIN_SLOTS);
      else if (cfg_slots > SLW'(MAX_SLOTS)) eff_slots = SLW'(MAX_SLOTS);
      else                                  eff_slots = cfg_slots;
   end
   assign frame_last = CW'(int'(eff_slots) * SLOT_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bcnt <= '0;
      else if (!cfg_en)            bcnt <= '0;
      else if (bcnt >= frame_last) bcnt <= '0;
      else                         bcnt <= bcnt + CW'(1);
   end

   assign pcm_fs     = cfg_en && ((bcnt == '0) || (cfg_fs_long && bcnt < CW'(FS_LONG)));
   assign off        = bcnt - CW'(cfg_start);
   assign in_slot    = cfg_en && (bcnt >= CW'(cfg_start)) && (off < CW'(SAMPLE_W));
   assign idx        = off[IW-1:0];
   assign slot_first = in_slot && (idx == '0);
   assign slot_last  = in_slot && (idx == IW'(SAMPLE_W - 1));
   assign pos        = cfg_lsb_first ? idx : IW'(SAMPLE_W - 1) - idx;

   // queues
   logic [SAMPLE_W-1:0] tx_head, tx_sh, cur_word, rx_sh, rx_word;
   logic                tx_empty, tx_full, rx_full, rx_empty;

   pcm_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .wr(tx_push), .wdata(tx_data),
      .rd(slot_first), .rdata(tx_head), .level(tx_level),
      .full(tx_full), .empty(tx_empty));

   pcm_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .wr(slot_last), .wdata(rx_word),
      .rd(rx_pop), .rdata(rx_data), .level(rx_level),
      .full(rx_full), .empty(rx_empty));

   // transmit path
   assign cur_word   = slot_first ? (tx_empty ? '0 : tx_head) : tx_sh;
   assign pcm_dtx    = in_slot && cur_word[pos];
   assign pcm_dtx_oe = in_slot && !(cfg_tri_last && slot_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_sh <= '0;
      else if (slot_first) tx_sh <= cur_word;
   end

   // receive path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_sh <= '0;
      else if (in_slot) rx_sh[pos] <= pcm_drx;
   end
   always_comb begin
      rx_word      = rx_sh;
      rx_word[pos] = pcm_drx;
   end

   // DMA handshakes, one per direction
   logic [1:0] hs_cond, hs_end, hs_req, hs_fault;
   assign hs_cond = {tx_level < cfg_tx_thr, rx_level >= cfg_rx_thr};
   assign hs_end  = {tx_dend, rx_dend};
   for (genvar d = 0; d < 2; d++) begin : g_dma
      pcm_dma_hs u_hs (
         .clk(clk), .rst_n(rst_n), .dma_en(cfg_dma_en), .cond(hs_cond[d]),
         .dend(hs_end[d]), .dreq(hs_req[d]), .fault(hs_fault[d]));
   end
   assign rx_dreq = hs_req[0];
   assign tx_dreq = hs_req[1];

   // interrupt causes
   logic [CAUSE_N-1:0] sticky_q, sticky_set, live;
   always_comb begin
      sticky_set            = '0;
      sticky_set[C_RX_OVR]  = slot_last && rx_full;
      sticky_set[C_TX_UDR]  = slot_first && tx_empty;
      sticky_set[C_DMA_FLT] = |hs_fault;
      live                  = '0;
      live[C_RX_THR]        = hs_cond[0];
      live[C_TX_THR]        = hs_cond[1];
   end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~irq_clr) | sticky_set;
   end
   assign irq_cause = sticky_q | live;
   assign irq       = |irq_cause;

   // R6
   udr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_first && tx_empty) |=> irq_cause[C_TX_UDR]);
   // R5
   ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last && rx_full) |=> (irq_cause[C_RX_OVR] && rx_full));
   // R10
   flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_dend && !rx_dreq) || (tx_dend && !tx_dreq)) |=> irq_cause[C_DMA_FLT]);
   // R2
   fs_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pcm_fs && !cfg_fs_long) |=> (!pcm_fs || cfg_fs_long));
   // R3
   oe_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_dtx_oe |-> (cfg_en && bcnt >= CW'(cfg_start)));
endmodule

// File: tb/sim_pcm_chan.sv
module sim_pcm_chan;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       cfg_en = 0, cfg_fs_long = 0, cfg_lsb_first = 0, cfg_tri_last = 0, cfg_dma_en = 0;
   logic [7:0] cfg_slots = 8'd4;
   logic [9:0] cfg_start = 10'd5;
   logic [5:0] cfg_rx_thr = 6'd33, cfg_tx_thr = 6'd0;
   logic       pcm_fs, pcm_dtx, pcm_dtx_oe, pcm_drx;
   logic       rx_pop = 0, tx_push = 0, rx_dend = 0, tx_dend = 0;
   logic [7:0] rx_data, tx_data = 0;
   logic [5:0] rx_level, tx_level;
   logic       rx_dreq, tx_dreq, irq;
   logic [4:0] irq_clr = 0, irq_cause;

   assign pcm_drx = pcm_dtx_oe ? pcm_dtx : 1'b1;

   pcm_chan u0 (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_slots(cfg_slots), .cfg_start(cfg_start),
      .cfg_fs_long(cfg_fs_long), .cfg_lsb_first(cfg_lsb_first), .cfg_tri_last(cfg_tri_last),
      .cfg_dma_en(cfg_dma_en), .cfg_rx_thr(cfg_rx_thr), .cfg_tx_thr(cfg_tx_thr),
      .pcm_fs(pcm_fs), .pcm_dtx(pcm_dtx), .pcm_dtx_oe(pcm_dtx_oe), .pcm_drx(pcm_drx),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level),
      .tx_push(tx_push), .tx_data(tx_data), .tx_level(tx_level),
      .rx_dreq(rx_dreq), .rx_dend(rx_dend), .tx_dreq(tx_dreq), .tx_dend(tx_dend),
      .irq_clr(irq_clr), .irq_cause(irq_cause), .irq(irq));

   int         n_chk = 0, n_bad = 0;
   logic [7:0] txm[$];
   logic [7:0] exp_q[$];
   bit         mon_on = 0;
   bit         done = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push_tx(logic [7:0] w, bit model);
      @(posedge clk); #1;
      tx_push = 1; tx_data = w;
      if (model) txm.push_back(w);
      @(posedge clk); #1;
      tx_push = 0;
   endtask

   task automatic pulse_clr(logic [4:0] m);
      @(posedge clk); #1; irq_clr = m;
      @(posedge clk); #1; irq_clr = 0;
   endtask

   // model: at each window start, predict the received sample; check serial order
   logic [7:0] raw, expw, ser;
   int         k = 0;
   bit         coll = 0, prev_oe = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (pcm_dtx_oe && !prev_oe) begin
            raw  = (txm.size() > 0) ? txm.pop_front() : 8'h00;
            expw = raw;
            if (cfg_tri_last) expw[cfg_lsb_first ? 7 : 0] = 1'b1;
            if (exp_q.size() < 32) exp_q.push_back(expw);
            k = 0; coll = 1; ser = 0;
         end
         if (coll) begin
            ser[k] = pcm_dtx;
            k++;
            if (k == 7) begin
               logic [6:0] want;
               for (int j = 0; j < 7; j++) want[j] = cfg_lsb_first ? raw[j] : raw[7-j];
               // R4 serial order
               check(ser[6:0] == want, "R4", int'(ser[6:0]), int'(want));
               coll = 0;
            end
         end
         prev_oe = pcm_dtx_oe;
      end
   end

   // monitor: scoreboard compare of received samples
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && rx_level > 0) begin
            if (exp_q.size() == 0) check(0, "R5", int'(rx_data), -1);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               // R5 capture / R6 zero fill / R7 released last bit
               check(rx_data == e, "R5", int'(rx_data), int'(e));
            end
            @(posedge clk); #1 rx_pop = 1;
            @(posedge clk); #1 rx_pop = 0;
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         report();
      end
   end

   initial begin
      int fs_cnt, oe_cnt, first_oe, t;
      tick(3);
      // reset state
      check(rx_level == 0 && tx_level == 0, "R1", int'(rx_level), 0);
      check(!rx_dreq && !tx_dreq && !pcm_fs, "R9", int'({rx_dreq, tx_dreq, pcm_fs}), 0);
      check(irq_cause == 0 && !irq, "R11", int'(irq_cause), 0);
      rst_n = 1;
      tick(2);

      // short sync, MSB first, window at bit 5
      push_tx(8'hA5, 1); push_tx(8'h3C, 1); push_tx(8'h81, 1);
      mon_on = 1;
      @(posedge clk); #1 cfg_en = 1;
      fs_cnt = 0; oe_cnt = 0; first_oe = -1;
      for (int c = 0; c < 64; c++) begin
         @(negedge clk);
         if (pcm_fs) fs_cnt++;
         if (pcm_dtx_oe && c < 32) begin
            oe_cnt++;
            if (first_oe < 0) first_oe = c;
         end
      end
      check(fs_cnt == 2, "R2", fs_cnt, 2);
      check(oe_cnt == 8, "R3", oe_cnt, 8);
      check(first_oe == 5, "R3", first_oe, 5);
      tick(32 * 3);
      // R6 underrun after the queue ran dry
      check(irq_cause[3] == 1'b1, "R6", int'(irq_cause[3]), 1);
      cfg_en = 0;
      tick(4);
      pulse_clr(5'b01000);
      check(irq_cause[3] == 1'b0, "R11", int'(irq_cause[3]), 0);

      // long sync, LSB first
      cfg_fs_long = 1; cfg_lsb_first = 1;
      push_tx(8'h6B, 1); push_tx(8'h12, 1);
      @(posedge clk); #1 cfg_en = 1;
      fs_cnt = 0;
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         if (pcm_fs) fs_cnt++;
      end
      check(fs_cnt == 8, "R2", fs_cnt, 8);
      tick(32 * 3);
      cfg_en = 0; cfg_fs_long = 0; cfg_lsb_first = 0;
      tick(4);
      check(!pcm_fs, "R2", int'(pcm_fs), 0);

      // released last bit
      cfg_tri_last = 1;
      push_tx(8'h40, 1);
      @(posedge clk); #1 cfg_en = 1;
      oe_cnt = 0;
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         if (pcm_dtx_oe) oe_cnt++;
      end
      check(oe_cnt == 7, "R7", oe_cnt, 7);
      tick(32);
      cfg_en = 0; cfg_tri_last = 0;
      tick(4);

      // fill transmit queue past its depth
      for (int i = 0; i < 33; i++) push_tx(8'(i * 7 + 1), i < 32);
      @(negedge clk);
      check(tx_level == 32, "R1", int'(tx_level), 32);
      cfg_tx_thr = 6'd4;
      @(negedge clk);
      check(irq_cause[1] == 1'b0, "R8", int'(irq_cause[1]), 0);
      @(posedge clk); #1 cfg_en = 1;
      tick(32 * 34);
      @(negedge clk);
      check(tx_level == 0 && irq_cause[1], "R8", int'(tx_level), 0);
      cfg_dma_en = 1;
      tick(2);
      @(negedge clk);
      check(tx_dreq == 1'b1, "R9", int'(tx_dreq), 1);
      // burst end while the condition still holds: drop for one cycle, then re-raise
      @(posedge clk); #1 tx_dend = 1;
      @(posedge clk); #1 tx_dend = 0;
      @(negedge clk);
      check(tx_dreq == 1'b0, "R9", int'(tx_dreq), 0);
      @(negedge clk);
      check(tx_dreq == 1'b1, "R9", int'(tx_dreq), 1);
      cfg_tx_thr = 0;
      @(posedge clk); #1 tx_dend = 1;
      @(posedge clk); #1 tx_dend = 0;
      @(negedge clk);
      check(tx_dreq == 1'b0 && irq_cause[4] == 1'b0, "R10", int'(irq_cause[4]), 0);
      // burst end with no request outstanding
      @(posedge clk); #1 tx_dend = 1;
      @(posedge clk); #1 tx_dend = 0;
      @(negedge clk);
      check(irq_cause[4] == 1'b1, "R10", int'(irq_cause[4]), 1);

      // receive threshold request held until burst end
      mon_on = 0;
      cfg_rx_thr = 6'd2;
      t = 0;
      while (rx_level < 2 && t < 400) begin @(negedge clk); t++; end
      tick(2);
      @(negedge clk);
      check(rx_dreq == 1'b1 && irq_cause[0], "R9", int'(rx_dreq), 1);
      mon_on = 1;
      t = 0;
      while (rx_level != 0 && t < 400) begin @(negedge clk); t++; end
      mon_on = 0;
      @(negedge clk);
      check(rx_dreq == 1'b1, "R9", int'(rx_dreq), 1);
      check(irq_cause[0] == 1'b0, "R8", int'(irq_cause[0]), 0);
      @(posedge clk); #1 rx_dend = 1;
      @(posedge clk); #1 rx_dend = 0;
      @(negedge clk);
      check(rx_dreq == 1'b0, "R9", int'(rx_dreq), 0);
      cfg_dma_en = 0; cfg_rx_thr = 6'd33;

      // receive overrun
      t = 0;
      while (rx_level < 32 && t < 2000) begin @(negedge clk); t++; end
      tick(40);
      @(negedge clk);
      check(rx_level == 32, "R5", int'(rx_level), 32);
      check(irq_cause[2] == 1'b1, "R5", int'(irq_cause[2]), 1);
      cfg_en = 0;
      mon_on = 1;
      t = 0;
      while (rx_level != 0 && t < 400) begin @(negedge clk); t++; end
      tick(8);
      check(exp_q.size() == 0, "R5", exp_q.size(), 0);
      check(irq == 1'b1, "R11", int'(irq), 1);
      pulse_clr(5'b11100);
      @(negedge clk);
      check(irq_cause == 0 && !irq, "R11", int'(irq_cause), 0);

      done = 1;
      report();
   end
endmodule